// File: doc/BRIEF.md
# Threshold-Qualified Performance Event Counter

This block is one performance-monitoring counter together with its event-selection control register. Each clock cycle it receives a small per-cycle event count from two sources: the local hardware thread that owns the counter, and a sibling thread that shares the same core. The control register decides what the accumulator adds in that cycle:

- the raw count;
- one, when the count meets a programmable threshold, optionally with the test inverted;
- one, only on the cycle where that qualified condition turns from false to true.

The accumulator is 48 bits wide and wraps to zero. A wrap sets a sticky overflow bit, which drives an interrupt request when interrupts are enabled.

Software reaches the block through a register port with three addresses: 0 is the control word, 1 is the counter and 2 is the status word. Writes (`wr_en`) are always accepted and take effect at the next clock edge. A read (`rd_req`) is always accepted. It returns the register contents as they were before that edge, one cycle later, with `rd_valid` high for one cycle. Neither port has back-pressure. The event inputs are sampled every cycle with no handshake.

Top module: `perf_event_counter`

## Requirements
- R1: After reset, the control word, counter and status word all read 0, and `irq` is 0.
- R2: Control word (address 0) fields:
  - bit 18: edge mode;
  - bit 20: interrupt enable;
  - bit 21: count both sources;
  - bit 22: enable;
  - bit 23: invert;
  - bits 31:24: threshold.

  Every other bit, including the reserved bits 63:32, is dropped on write and reads back as 0.
- R3: While the enable bit is 0, the counter holds its value whatever the event inputs carry.
- R4: With threshold 0, each enabled cycle adds the raw event sum, and the invert and edge bits have no effect.
- R5: The event sum is `evt_local` alone when bit 21 is 0, and `evt_local + evt_remote` when bit 21 is 1.
- R6: With a nonzero threshold and invert 0, an enabled cycle adds 1 when sum >= threshold, otherwise 0.
- R7: With a nonzero threshold and invert 1, an enabled cycle adds 1 when sum < threshold, otherwise 0.
- R8: In edge mode with a nonzero threshold, 1 is added only when the qualified condition is true and was false in the previous cycle. The stored previous condition resets to 0 and is forced to 0 in every disabled cycle.
- R9: A carry out of the 48-bit counter wraps it and sets the sticky overflow bit (status bit 0). A write to address 2 loads bit 0, so writing 0 clears it. An overflow in the same cycle as such a write leaves the bit at 1.
- R10: `irq` is 1 exactly when the overflow bit and control bit 20 are both 1.
- R11: A write to address 1 loads the low 48 bits of the data and replaces any increment of that cycle. The counter reads back zero-extended, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_local | input | EVT_W | Per-cycle event count of the owning thread |
| evt_remote | input | EVT_W | Per-cycle event count of the sibling thread |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 counter, 2 status) |
| wr_data | input | 64 | Write data |
| rd_req | input | 1 | Register read request |
| rd_addr | input | 2 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_data | output | 64 | Read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults, `EVT_W = 4` and `CNT_W = 48`. With these values a two-source sum of up to 30 can lie on either side of an 8-bit threshold, so the at-threshold and one-below cases can be driven directly. A full-width counter preload puts the 48-bit wrap and its overflow race with a status write within a few cycles. Expected counts are worked out per cycle, including the idle cycles that an inverted threshold still counts and the write cycles that run under the previous control word.

// File: rtl/pec_pkg.sv
package pec_pkg;

  localparam int REG_W     = 64;
  localparam int THR_W     = 8;
  localparam int BIT_EDGE  = 18;
  localparam int BIT_IRQEN = 20;
  localparam int BIT_ALL   = 21;
  localparam int BIT_EN    = 22;
  localparam int BIT_INV   = 23;
  localparam int THR_LSB   = 24;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_COUNT  = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;

  typedef struct packed {
    logic [THR_W-1:0] thresh;
    logic             invert;
    logic             enable;
    logic             all_src;
    logic             irq_en;
    logic             edge_mode;
  } pec_cfg_t;

  function automatic pec_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    pec_cfg_t c;
    c.thresh    = w[THR_LSB +: THR_W];
    c.invert    = w[BIT_INV];
    c.enable    = w[BIT_EN];
    c.all_src   = w[BIT_ALL];
    c.irq_en    = w[BIT_IRQEN];
    c.edge_mode = w[BIT_EDGE];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input pec_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[THR_LSB +: THR_W] = c.thresh;
    w[BIT_INV]   = c.invert;
    w[BIT_EN]    = c.enable;
    w[BIT_ALL]   = c.all_src;
    w[BIT_IRQEN] = c.irq_en;
    w[BIT_EDGE]  = c.edge_mode;
    return w;
  endfunction

endpackage

// File: rtl/pec_ctrl_reg.sv
module pec_ctrl_reg
  import pec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_word,
  output pec_cfg_t         cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (wr_stb) cfg <= word_to_cfg(wr_word);
  end

  // R2: a written word lands in the defined fields only
  p_field_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (cfg.thresh == $past(wr_word[31:24]) && cfg.enable == $past(wr_word[22])
                && cfg.edge_mode == $past(wr_word[18])));

  // R2: no write, no change
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg));

endmodule

// File: rtl/pec_qualify.sv
module pec_qualify
  import pec_pkg::*;
#(
  parameter int EVT_W = 4,
  localparam int SUM_W = EVT_W + 1,
  localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pec_cfg_t         cfg,
  input  logic [EVT_W-1:0] evt_local,
  input  logic [EVT_W-1:0] evt_remote,
  output logic [SUM_W-1:0] inc
);

  logic [SUM_W-1:0] sum;
  logic [CMP_W-1:0] sum_x, thr_x;
  logic             thr_on, meets, cond, prev_cond;

  always_comb begin
    sum = {1'b0, evt_local};
    if (cfg.all_src) sum = sum + {1'b0, evt_remote};
  end

  assign sum_x  = CMP_W'(sum);
  assign thr_x  = CMP_W'(cfg.thresh);
  assign thr_on = (cfg.thresh != '0);
  assign meets  = (sum_x >= thr_x);
  assign cond   = cfg.invert ? !meets : meets;

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg.enable) prev_cond <= 1'b0;
    else                       prev_cond <= cond;
  end

  always_comb begin
    if (!thr_on)            inc = sum;
    else if (cfg.edge_mode) inc = SUM_W'(cond && !prev_cond);
    else                    inc = SUM_W'(cond);
  end

  // R6/R7: a qualified cycle adds at most one
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_on |-> (inc <= SUM_W'(1)));

  // R8: edge mode never counts two cycles in a row under a steady setting
  p_edge_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.enable && cfg.edge_mode && thr_on && inc != '0)
    |=> (inc == '0 || !$stable(cfg)));

endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int CNT_W = 48,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [INC_W-1:0] inc,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             stat_wr,
  input  logic             stat_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic [CNT_W:0] nxt;
  logic           carry;

  assign nxt   = {1'b0, cnt} + {{(CNT_W+1-INC_W){1'b0}}, inc};
  assign carry = count_en && !cnt_wr && nxt[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt_wr)   cnt <= cnt_wdata;
    else if (count_en) cnt <= nxt[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (carry)   ovf <= 1'b1;
    else if (stat_wr) ovf <= stat_wdata;
  end

  // R3: disabled and unwritten means frozen
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !cnt_wr) |=> (cnt == $past(cnt)));

  // R11: software load wins over counting
  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(cnt_wdata)));

  // R9: passing the all-ones value wraps and flags
  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !cnt_wr && cnt == '1 && inc != '0) |=> (ovf && cnt < CNT_W'(INC_W'(-1))));

  // R9: the flag is sticky without a status write
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !stat_wr) |=> ovf);

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pec_pkg::*;
#(
  parameter int EVT_W = 4,
  parameter int CNT_W = 48,
  localparam int INC_W = EVT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_local,
  input  logic [EVT_W-1:0] evt_remote,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [63:0]      wr_data,
  input  logic             rd_req,
  input  logic [1:0]       rd_addr,
  output logic             rd_valid,
  output logic [63:0]      rd_data,
  output logic             irq
);

  pec_cfg_t         cfg;
  logic [INC_W-1:0] inc;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             wr_ctrl, wr_cnt, wr_stat;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == A_COUNT);
  assign wr_stat = wr_en && (wr_addr == A_STATUS);

  pec_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_ctrl),
    .wr_word (wr_data),
    .cfg     (cfg)
  );

  pec_qualify #(.EVT_W(EVT_W)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .evt_local  (evt_local),
    .evt_remote (evt_remote),
    .inc        (inc)
  );

  pec_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_en   (cfg.enable),
    .inc        (inc),
    .cnt_wr     (wr_cnt),
    .cnt_wdata  (wr_data[CNT_W-1:0]),
    .stat_wr    (wr_stat),
    .stat_wdata (wr_data[0]),
    .cnt        (cnt),
    .ovf        (ovf)
  );

  assign irq = ovf && cfg.irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        unique case (rd_addr)
          A_CTRL:   rd_data <= cfg_to_word(cfg);
          A_COUNT:  rd_data <= {{(64-CNT_W){1'b0}}, cnt};
          A_STATUS: rd_data <= {63'd0, ovf};
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  // R10: a request is raised only on a recorded overflow
  p_irq_needs_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf);

  // R11: every read request answers exactly one cycle later
  p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

endmodule

// File: tb/test_perf_event_counter.sv
module test_perf_event_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt_local = '0, evt_remote = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        irq;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  perf_event_counter i_perf_event_counter (
    .clk(clk), .rst_n(rst_n), .evt_local(evt_local), .evt_remote(evt_remote),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq(irq)
  );

  // monitor: compare each returned read with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read data %h (expected none)", rd_data);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ev(input logic [3:0] l, input logic [3:0] r);
    evt_local = l;
    evt_remote = r;
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [63:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(2'd0, 64'd0, "R1 ctrl");
    rd(2'd1, 64'd0, "R1 count");
    rd(2'd2, 64'd0, "R1 status");

    // R2 field map, reserved bits dropped
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, 64'h0000_0000_FFF4_0000, "R2 ctrl readback");
    wr(2'd0, 64'd0);
    wr(2'd1, 64'd0);

    // R4/R5 raw count, local only
    wr(2'd0, 64'h0040_0000);
    ev(3, 5); step(1);
    ev(7, 0); step(1);
    ev(15, 15); step(1);
    ev(0, 0);
    rd(2'd1, 64'd25, "R5 local-only raw sum");
    // R4 invert/edge ignored at threshold 0, both sources
    wr(2'd0, 64'h00E4_0000);
    ev(3, 5); step(2);
    ev(0, 0);
    rd(2'd1, 64'd41, "R4 raw sum with invert and edge set");

    // R6 threshold >= 8 on both sources
    wr(2'd0, 64'd0);
    wr(2'd1, 64'd0);
    wr(2'd0, 64'h0860_0000);
    ev(4, 4); step(1);
    ev(2, 3); step(1);
    ev(15, 0); step(1);
    ev(7, 0); step(1);
    ev(0, 0);
    rd(2'd1, 64'd2, "R6 threshold compare");

    // R7 inverted, local only (idle cycles also count)
    wr(2'd0, 64'h08C0_0000);
    wr(2'd1, 64'd0);
    ev(9, 0); step(1);
    ev(8, 0); step(1);
    ev(3, 0); step(1);
    ev(0, 15); step(1);
    ev(0, 0);
    wr(2'd0, 64'd0);
    rd(2'd1, 64'd3, "R7 inverted threshold");

    // R8 edge mode, threshold 4, both sources
    wr(2'd0, 64'h0464_0000);
    wr(2'd1, 64'd0);
    ev(4, 0); step(1);
    ev(5, 0); step(1);
    ev(0, 0); step(1);
    ev(2, 2); step(1);
    ev(1, 2); step(1);
    ev(3, 3); step(1);
    ev(0, 0);
    wr(2'd0, 64'd0);
    rd(2'd1, 64'd3, "R8 rising edges only");

    // R8 previous condition cleared while disabled; R3 hold
    ev(5, 0);
    wr(2'd0, 64'h0464_0000);
    step(2);
    wr(2'd0, 64'h0424_0000);
    step(2);
    rd(2'd1, 64'd4, "R3 hold while disabled");
    wr(2'd0, 64'h0464_0000);
    step(1);
    ev(0, 0);
    wr(2'd0, 64'd0);
    rd(2'd1, 64'd5, "R8 edge re-arms after disable");

    // R9/R10 wrap, sticky flag, interrupt
    wr(2'd1, 64'h0000_FFFF_FFFF_FFFE);
    wr(2'd0, 64'h0050_0000);
    ev(1, 0); step(2);
    ev(3, 0); step(1);
    ev(0, 0);
    chk_irq(1'b1, "R10 irq on overflow");
    rd(2'd1, 64'd3, "R9 wrapped count");
    rd(2'd2, 64'd1, "R9 overflow set");
    wr(2'd0, 64'h0040_0000);
    chk_irq(1'b0, "R10 irq masked");
    rd(2'd2, 64'd1, "R9 overflow sticky");
    wr(2'd2, 64'd0);
    rd(2'd2, 64'd0, "R9 overflow cleared");
    wr(2'd1, 64'h0000_FFFF_FFFF_FFFF);
    ev(1, 0);
    wr(2'd2, 64'd0);
    ev(0, 0);
    rd(2'd2, 64'd1, "R9 overflow beats clear");
    rd(2'd1, 64'd0, "R9 wrap to zero");

    // R11 load priority, truncation, unused address
    ev(5, 0);
    wr(2'd1, 64'd100);
    ev(0, 0);
    rd(2'd1, 64'd100, "R11 load beats increment");
    wr(2'd1, 64'hABCD_0000_0000_0007);
    rd(2'd1, 64'd7, "R11 load truncated to 48 bits");
    rd(2'd3, 64'd0, "R11 unused address");

    step(3);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL missing %0d read responses (expected 0)", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish (expected completion)");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule